// File: doc/BRIEF.md
# Read-Serviced Watchdog Timer

This block is a watchdog counter for a larger controller. Once software enables it, it counts base-clock cycles. If the count reaches the selected terminal value before software services it, the timer latches an expired state. While it is also enabled, it drives a system-wide reset request.

Software services the timer only by reading its control/status word. Any read restarts the count and clears a pending expiry. A write changes only the enable bit. A two-bit static configuration input, standing in for a board jumper, picks one of four terminal counts. The expired state stays visible in the status word even after the watchdog is disabled. Software can therefore learn afterwards that a timeout happened.

Top module: `rdsvc_wdt`

## Requirements
- R1: While `rst_n` is low, and after reset, the watchdog is disabled, not expired, `sys_rst_o` is 0 and `rd_data` is all zero.
- R2: A cycle with `wr_en` high loads `wr_data[0]` into the enable state from the next cycle on; `rd_data[0]` shows that state (1 = enabled). The other write bits have no effect.
- R3: With timeout code c on `tmo_sel` (0..3), the terminal count is L(c) = BASE << (SHIFT*c). For the defaults BASE=8 and SHIFT=1 this gives 8, 16, 32 and 64 cycles. `rd_data[2]` becomes 1 exactly L(c) clock edges after the edge that enabled the watchdog or that completed the last service read.
- R4: A cycle with `rd_en` high services the timer. From the next cycle the count restarts from zero and the expired state is 0. In the read cycle itself, `rd_data` shows the state as it was before the service.
- R5: `rd_data[2]` is the expired state (1 = expired). It stays 1 after the watchdog is disabled, until a service read. All `rd_data` bits other than 0 and 2 read 0.
- R6: `sys_rst_o` is 1 exactly when the watchdog is enabled and expired. It stays 1 until a service read or a write that disables the watchdog.
- R7: While the watchdog is disabled, the count is held at zero and the expired state cannot become 1. After the watchdog is re-enabled, a full L(c) cycles pass before expiry.
- R8: A write that keeps the watchdog enabled does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; one count per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_sel | input | 2 | Static timeout code choosing the terminal count |
| rd_en | input | 1 | Read strobe of the control/status word (services the timer) |
| wr_en | input | 1 | Write strobe of the control/status word |
| wr_data | input | DW | Write data; bit 0 is the enable |
| rd_data | output | DW | Status word: bit 0 enable, bit 2 expired |
| sys_rst_o | output | 1 | System-wide reset request |

## Verification
On every cycle, the assertions check four things:
- the quiet state during reset;
- that a write lands in the enable bit one cycle later;
- that a service read clears the expired flag;
- that expiry only arises from an enabled cycle, and that the reset request holds until it is serviced or disabled.

The exact timeout length for each code, and the restart from zero after a read or after re-enabling, can only be shown by the bench. The bench sweeps all four codes and counts the cycles to the edge. So can the fact that an expired flag survives disabling, and that a rewrite of the enable does not restart the count.

// File: rtl/rdsvc_wdt_pkg.sv
package rdsvc_wdt_pkg;

    localparam int unsigned EN_POS  = 0;
    localparam int unsigned EXP_POS = 2;
    localparam int unsigned NUM_CODES = 4;

    typedef struct packed {
        logic en;
    } ctl_t;

endpackage

// File: rtl/rdsvc_wdt_limit.sv
module rdsvc_wdt_limit #(
    parameter int unsigned BASE  = 8,
    parameter int unsigned SHIFT = 1,
    parameter int unsigned CW    = 7
) (
    input  logic [1:0]    sel_i,
    output logic [CW-1:0] limit_o
);
    import rdsvc_wdt_pkg::*;

    logic [CW-1:0] table_w [NUM_CODES];

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
        localparam int unsigned LIM = BASE << (SHIFT * g);
        assign table_w[g] = CW'(LIM);
    end

    always_comb begin
        limit_o = table_w[sel_i];
    end

endmodule

// File: rtl/rdsvc_wdt_count.sv
module rdsvc_wdt_count #(
    parameter int unsigned CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          clear_i,
    input  logic [CW-1:0] limit_i,
    output logic          expired_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          exp;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.cnt = '0;
            st_d.exp = 1'b0;
        end else if (!run_i) begin
            st_d.cnt = '0;
        end else if (!st_q.exp) begin
            if (st_q.cnt >= limit_i - CW'(1)) begin
                st_d.exp = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expired_o = st_q.exp;

endmodule

// File: rtl/rdsvc_wdt.sv
module rdsvc_wdt #(
    parameter int unsigned DW    = 16,
    parameter int unsigned BASE  = 8,
    parameter int unsigned SHIFT = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    tmo_sel,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          sys_rst_o
);
    import rdsvc_wdt_pkg::*;

    localparam int unsigned MAX_LIM = BASE << (SHIFT * (NUM_CODES - 1));
    localparam int unsigned CW      = $clog2(MAX_LIM) + 1;

    ctl_t          ctl_d, ctl_q;
    logic [CW-1:0] limit_w;
    logic          expired_w;

    rdsvc_wdt_limit #(.BASE(BASE), .SHIFT(SHIFT), .CW(CW)) u_limit (
        .sel_i   (tmo_sel),
        .limit_o (limit_w)
    );

    rdsvc_wdt_count #(.CW(CW)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ctl_q.en),
        .clear_i   (rd_en),
        .limit_i   (limit_w),
        .expired_o (expired_w)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d.en = wr_data[EN_POS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        rd_data          = '0;
        rd_data[EN_POS]  = ctl_q.en;
        rd_data[EXP_POS] = expired_w;
    end

    assign sys_rst_o = ctl_q.en & expired_w;

endmodule

// File: rtl/rdsvc_wdt_chk.sv
module rdsvc_wdt_chk #(
    parameter int unsigned DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_en,
    input logic          wr_en,
    input logic [DW-1:0] wr_data,
    input logic [DW-1:0] rd_data,
    input logic          sys_rst_o
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!sys_rst_o && rd_data == '0));

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[0] == $past(wr_data[0])));

    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_data[2]);

    a_r6_reset_held: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_o && !rd_en && !(wr_en && !wr_data[0])) |=> sys_rst_o);

    a_r7_expiry_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[2]) |-> $past(rd_data[0]));

endmodule

bind rdsvc_wdt rdsvc_wdt_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .sys_rst_o (sys_rst_o)
);

// File: tb/rdsvc_wdt_bench.sv
`timescale 1ns/1ps
module rdsvc_wdt_bench;
    localparam int DW    = 16;
    localparam int BASE  = 8;
    localparam int SHIFT = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    tmo_sel = 2'd0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          sys_rst_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rdsvc_wdt #(.DW(DW), .BASE(BASE), .SHIFT(SHIFT)) u_rdsvc_wdt (
        .clk(clk), .rst_n(rst_n), .tmo_sel(tmo_sel), .rd_en(rd_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .sys_rst_o(sys_rst_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic write_en(input logic [DW-1:0] v);
        wr_en = 1'b1; wr_data = v;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic svc_read();
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    function automatic int lim(input int c);
        return BASE << (SHIFT * c);
    endfunction

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #1;
        check(rd_data == '0 && !sys_rst_o, "R1 in reset", int'(rd_data), 0);
        do_reset();
        check(rd_data == '0 && !sys_rst_o, "R1 after reset", int'(rd_data), 0);

        for (int c = 0; c < 4; c++) begin
            tmo_sel = 2'(c);
            do_reset();
            write_en(16'hFFFE);
            check(rd_data[0] == 1'b0, "R2 other bits ignored", int'(rd_data), 0);
            write_en(16'h0001);
            check(rd_data == 16'h0001, "R2 enable read back", int'(rd_data), 1);
            wait_n(lim(c) - 1);
            check(rd_data[2] == 1'b0 && !sys_rst_o, "R3 not yet expired", int'(rd_data), 1);
            tick();
            check(rd_data == 16'h0005, "R3 expired at terminal", int'(rd_data), 5);
            check(sys_rst_o == 1'b1, "R6 reset asserted", int'(sys_rst_o), 1);
            wait_n(5);
            check(sys_rst_o == 1'b1, "R6 reset held", int'(sys_rst_o), 1);
            rd_en = 1'b1;
            #1;
            check(rd_data == 16'h0005, "R4 read shows pre-service state", int'(rd_data), 5);
            tick();
            rd_en = 1'b0;
            check(rd_data == 16'h0001 && !sys_rst_o, "R4 service clears", int'(rd_data), 1);
            wait_n(lim(c) - 1);
            check(rd_data[2] == 1'b0, "R4 restart full window", int'(rd_data), 1);
            tick();
            check(rd_data[2] == 1'b1, "R4 expiry after restart", int'(rd_data), 5);
        end

        // mid-window service and R8 rewrite of enable
        tmo_sel = 2'd1;
        do_reset();
        write_en(16'h0001);
        wait_n(10);
        svc_read();
        wait_n(lim(1) - 1);
        check(rd_data[2] == 1'b0, "R4 mid-window read restarts", int'(rd_data), 1);
        tick();
        check(rd_data[2] == 1'b1, "R4 mid-window read expiry", int'(rd_data), 5);
        svc_read();
        wait_n(5);
        write_en(16'h0001);
        wait_n(lim(1) - 7);
        check(rd_data[2] == 1'b0, "R8 before terminal", int'(rd_data), 1);
        tick();
        check(rd_data[2] == 1'b1, "R8 write did not restart", int'(rd_data), 5);

        // R5/R6: disable while expired
        write_en(16'h0000);
        check(rd_data == 16'h0004 && !sys_rst_o, "R5 expired kept when disabled", int'(rd_data), 4);
        check(sys_rst_o == 1'b0, "R6 released by disable", int'(sys_rst_o), 0);
        svc_read();
        check(rd_data == 16'h0000, "R5 cleared by read", int'(rd_data), 0);

        // R7: disabled holds count
        wait_n(3 * lim(1));
        check(rd_data[2] == 1'b0, "R7 no expiry while disabled", int'(rd_data), 0);
        write_en(16'h0001);
        wait_n(lim(1) - 1);
        check(rd_data[2] == 1'b0, "R7 full window after enable", int'(rd_data), 1);
        tick();
        check(rd_data[2] == 1'b1, "R7 expiry after re-enable", int'(rd_data), 5);

        // R7: disable mid-window then re-enable
        svc_read();
        wait_n(9);
        write_en(16'h0000);
        wait_n(4);
        write_en(16'h0001);
        wait_n(lim(1) - 1);
        check(rd_data[2] == 1'b0, "R7 count zeroed by disable", int'(rd_data), 1);
        tick();
        check(rd_data[2] == 1'b1, "R7 expiry after zeroed count", int'(rd_data), 5);

        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            if (done) break;
            @(posedge clk);
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=0 exp=1");
        end
        #2;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule